// File: doc/BRIEF.md
# Code-Space Patch and Breakpoint Unit

This block sits beside a processor's code-region request path. Each request carries an address and a tag that says whether it is an instruction fetch or a literal (data) load. The block compares the request against two banks of programmable comparators. There are six comparators for fetches and two for literal loads. On a match it does one of two things. It can redirect the access to a word in a remap table that lives in system address space. Or, for an instruction comparator set to breakpoint mode, it supplies a breakpoint opcode that replaces the fetched instruction.

Configuration goes through a simple register write/read port. The lookup itself is combinational. The response (the final address, a remap flag, a breakpoint flag and the opcode) comes from registers and is valid one cycle after the request is sampled. Requests that hit nothing leave with their address unchanged.

Top module: `code_patch_unit`

## Requirements
- R1: The two literal comparators (slots 6 and 7) match only requests with `req_is_fetch`=0, and they never produce a breakpoint.
- R2: The six instruction comparators (slots 0 to 5) match only requests with `req_is_fetch`=1.
- R3: A remap hit gives `rsp_remap`=1 and `rsp_addr` = 0x2000_0000 + (base bits [28:5] << 5) + 4*slot + request bits [1:0].
- R4: An instruction comparator whose bit1 is set gives `rsp_bkpt`=1 instead of a remap. `rsp_opcode` holds 0xBE00 in bits [15:0] when request address bit1 is 0, or in bits [31:16] when it is 1. The other halfword is zero. `rsp_addr` equals the request address. When `rsp_bkpt`=0, `rsp_opcode` is zero.
- R5: A request whose address bits [31:29] are not all zero never matches, and it passes through unchanged.
- R6: A comparator matches only when the unit enable (register 0 bit0) and its own enable (bit0) are both 1, and its address bits [28:2] equal those of the request.
- R7: If several comparators of the same bank match, the lowest-numbered slot wins.
- R8: The register map is as follows. Index 0 is the unit enable in bit0. Index 1 is the remap base in bits [28:5]. Indices 2 to 7 are instruction comparators 0 to 5, and indices 8 and 9 are literal comparators 0 and 1. A comparator register holds the enable in bit0, breakpoint mode in bit1 and the word address in bits [28:2]. On readback, unimplemented bits and a literal comparator's bit1 read as 0. `cfg_rdata` shows the register selected by `cfg_addr` one cycle later. A write changes the lookup for a request sampled on the next clock edge.
- R9: `rsp_valid` equals `req_valid` delayed by one cycle. Without a request, `rsp_remap` and `rsp_bkpt` are 0.
- R10: After reset, all registers are zero and every response output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register index for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered readback of the selected register |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request address |
| req_is_fetch | input | 1 | 1 = instruction fetch, 0 = literal load |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_addr | output | 32 | Remapped or original address |
| rsp_remap | output | 1 | Access was redirected |
| rsp_bkpt | output | 1 | Breakpoint opcode substituted |
| rsp_opcode | output | 32 | Breakpoint opcode in the selected halfword |

## Verification
The assertions assume two things about the inputs. The request tag and address are stable for the cycle in which they are sampled. The register port is not written while the reset is active. The bench drives every input on the falling edge and holds it through the next rising edge. It writes configuration only after reset is released. It sweeps every comparator address with all four byte offsets and both tag values, under several enable, mode and overlap settings, and also sends out-of-region aliases of the same addresses.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
  localparam int CPT_AW = 32;
  localparam logic [15:0] CPT_BKPT_OP = 16'hBE00;
  localparam logic [2:0] CPT_SYS_TOP = 3'b001;

  typedef struct packed {
    logic        en;
    logic        bkpt;
    logic [26:0] word;
  } cpt_cmp_t;
endpackage

// File: rtl/cpt_cfg_regs.sv
module cpt_cfg_regs
  import cpt_pkg::*;
#(
  parameter int N_INSN = 6,
  parameter int N_LIT  = 2,
  parameter int CFG_AW = 4,
  localparam int N_CMP = N_INSN + N_LIT
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [CFG_AW-1:0]       cfg_addr,
  input  logic [31:0]             cfg_wdata,
  output logic [31:0]             cfg_rdata,
  output logic                    unit_en,
  output logic [23:0]             remap_base,
  output cpt_cmp_t [N_CMP-1:0]    cmp
);
  logic [31:0] rd_next;
  logic        unused_wbits;
  assign unused_wbits = ^cfg_wdata[31:29];

  always_ff @(posedge clk) begin
    if (rst) begin
      unit_en    <= 1'b0;
      remap_base <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == CFG_AW'(0)) unit_en <= cfg_wdata[0];
      if (cfg_addr == CFG_AW'(1)) remap_base <= cfg_wdata[28:5];
    end
  end

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (rst) begin
        cmp[k] <= '0;
      end else if (cfg_we && cfg_addr == CFG_AW'(k + 2)) begin
        cmp[k].en   <= cfg_wdata[0];
        cmp[k].bkpt <= (k < N_INSN) ? cfg_wdata[1] : 1'b0;
        cmp[k].word <= cfg_wdata[28:2];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (cfg_addr == CFG_AW'(0)) rd_next = {31'b0, unit_en};
    if (cfg_addr == CFG_AW'(1)) rd_next = {3'b0, remap_base, 5'b0};
    for (int k = 0; k < N_CMP; k++) begin
      if (cfg_addr == CFG_AW'(k + 2))
        rd_next = {3'b0, cmp[k].word, cmp[k].bkpt, cmp[k].en};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_next;
  end
endmodule

// File: rtl/cpt_cmp_bank.sv
module cpt_cmp_bank
  import cpt_pkg::*;
#(
  parameter int N = 6,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  cpt_cmp_t [N-1:0] cmp,
  input  logic             active,
  input  logic [26:0]      word,
  output logic             hit,
  output logic [IW-1:0]    idx,
  output logic             bkpt
);
  logic [N-1:0] match;

  for (genvar i = 0; i < N; i++) begin : g_match
    assign match[i] = active && cmp[i].en && (cmp[i].word == word);
  end

  always_comb begin
    idx  = '0;
    bkpt = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        idx  = IW'(i);
        bkpt = cmp[i].bkpt;
      end
    end
  end

  assign hit = |match;
endmodule

// File: rtl/code_patch_unit.sv
module code_patch_unit
  import cpt_pkg::*;
#(
  parameter int N_INSN = 6,
  parameter int N_LIT  = 2,
  localparam int N_CMP  = N_INSN + N_LIT,
  localparam int CFG_AW = $clog2(N_CMP + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  input  logic              req_is_fetch,
  output logic              rsp_valid,
  output logic [31:0]       rsp_addr,
  output logic              rsp_remap,
  output logic              rsp_bkpt,
  output logic [31:0]       rsp_opcode
);
  localparam int IW_I = (N_INSN > 1) ? $clog2(N_INSN) : 1;
  localparam int IW_L = (N_LIT > 1) ? $clog2(N_LIT) : 1;
  localparam int SW   = $clog2(N_CMP);

  logic                 unit_en;
  logic [23:0]          remap_base;
  cpt_cmp_t [N_CMP-1:0] cmp;

  cpt_cfg_regs #(.N_INSN(N_INSN), .N_LIT(N_LIT), .CFG_AW(CFG_AW)) i_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .unit_en(unit_en),
    .remap_base(remap_base), .cmp(cmp)
  );

  logic in_code, act_i, act_l;
  assign in_code = (req_addr[31:29] == 3'b000);
  assign act_i   = req_valid && unit_en && in_code && req_is_fetch;
  assign act_l   = req_valid && unit_en && in_code && !req_is_fetch;

  logic            hit_i, hit_l, bkpt_i, unused_lit_bkpt;
  logic [IW_I-1:0] idx_i;
  logic [IW_L-1:0] idx_l;

  cpt_cmp_bank #(.N(N_INSN)) i_bank_insn (
    .cmp(cmp[N_INSN-1:0]), .active(act_i), .word(req_addr[28:2]),
    .hit(hit_i), .idx(idx_i), .bkpt(bkpt_i)
  );

  cpt_cmp_bank #(.N(N_LIT)) i_bank_lit (
    .cmp(cmp[N_CMP-1:N_INSN]), .active(act_l), .word(req_addr[28:2]),
    .hit(hit_l), .idx(idx_l), .bkpt(unused_lit_bkpt)
  );

  logic [SW-1:0] slot;
  logic [31:0]   tgt;
  assign slot = hit_i ? SW'(idx_i) : SW'(SW'(N_INSN) + SW'(idx_l));
  assign tgt  = ({CPT_SYS_TOP, 29'b0} | {3'b0, remap_base, 5'b0})
                + (32'(slot) << 2) + {30'b0, req_addr[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_addr   <= '0;
      rsp_remap  <= 1'b0;
      rsp_bkpt   <= 1'b0;
      rsp_opcode <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_addr   <= req_addr;
      rsp_remap  <= 1'b0;
      rsp_bkpt   <= 1'b0;
      rsp_opcode <= '0;
      if (hit_i && bkpt_i) begin
        rsp_bkpt   <= 1'b1;
        rsp_opcode <= req_addr[1] ? {CPT_BKPT_OP, 16'h0} : {16'h0, CPT_BKPT_OP};
      end else if (hit_i || hit_l) begin
        rsp_remap <= 1'b1;
        rsp_addr  <= tgt;
      end
    end
  end
endmodule

// File: rtl/cpt_checker.sv
module cpt_checker (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic        req_is_fetch,
  input logic        unit_en,
  input logic        rsp_valid,
  input logic [31:0] rsp_addr,
  input logic        rsp_remap,
  input logic        rsp_bkpt,
  input logic [31:0] rsp_opcode
);
  a_r5_outside_passthrough: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr[31:29] != 3'b000) |=>
      (rsp_addr == $past(req_addr) && !rsp_remap && !rsp_bkpt));

  a_r6_unit_off_no_hit: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !unit_en) |=> (!rsp_remap && !rsp_bkpt));

  a_r1_literal_no_bkpt: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_is_fetch) |=> !rsp_bkpt);

  a_r3_remap_region: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!rsp_remap ||
      (rsp_addr[31:29] == 3'b001 && rsp_addr[1:0] == $past(req_addr[1:0]))));

  a_r4_bkpt_opcode: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!rsp_bkpt || (rsp_addr == $past(req_addr) &&
      rsp_opcode == ($past(req_addr[1]) ? 32'hBE00_0000 : 32'h0000_BE00))));

  a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rsp_remap && rsp_bkpt));

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_remap && !rsp_bkpt));
endmodule

bind code_patch_unit cpt_checker i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .req_is_fetch(req_is_fetch), .unit_en(unit_en), .rsp_valid(rsp_valid),
  .rsp_addr(rsp_addr), .rsp_remap(rsp_remap), .rsp_bkpt(rsp_bkpt),
  .rsp_opcode(rsp_opcode)
);

// File: tb/test_code_patch_unit.sv
module test_code_patch_unit;
  localparam int NI = 6;
  localparam int NL = 2;
  localparam int NC = NI + NL;
  localparam int AW = $clog2(NC + 2);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic          req_valid = 1'b0;
  logic [31:0]   req_addr = '0;
  logic          req_is_fetch = 1'b0;
  logic          rsp_valid, rsp_remap, rsp_bkpt;
  logic [31:0]   rsp_addr, rsp_opcode;

  always #2ns clk = ~clk;

  code_patch_unit #(.N_INSN(NI), .N_LIT(NL)) i_code_patch_unit (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_is_fetch(req_is_fetch), .rsp_valid(rsp_valid),
    .rsp_addr(rsp_addr), .rsp_remap(rsp_remap), .rsp_bkpt(rsp_bkpt),
    .rsp_opcode(rsp_opcode)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        m_en = 0;
  logic [23:0] m_base = 0;
  logic        m_cen [NC];
  logic        m_bk  [NC];
  logic [26:0] m_word[NC];

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(idx); cfg_wdata = d;
    if (idx == 0) m_en = d[0];
    else if (idx == 1) m_base = d[28:5];
    else begin
      m_cen[idx-2]  = d[0];
      m_bk[idx-2]   = (idx - 2 < NI) ? d[1] : 1'b0;
      m_word[idx-2] = d[28:2];
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] rd_model(input int idx);
    if (idx == 0) return {31'b0, m_en};
    if (idx == 1) return {3'b0, m_base, 5'b0};
    return {3'b0, m_word[idx-2], m_bk[idx-2], m_cen[idx-2]};
  endfunction

  task automatic rd(input int idx, input string tag);
    @(negedge clk);
    cfg_addr = AW'(idx);
    @(negedge clk);
    chk(tag, "readback", cfg_rdata, rd_model(idx));
  endtask

  task automatic model(input logic [31:0] a, input logic f, output logic [31:0] ea,
                       output logic er, output logic eb, output logic [31:0] eo);
    bit found = 0;
    ea = a; er = 0; eb = 0; eo = 0;
    if (a[31:29] == 3'b000 && m_en) begin
      for (int k = 0; k < NC; k++) begin
        if (!found && (f ? (k < NI) : (k >= NI)) && m_cen[k] && m_word[k] == a[28:2]) begin
          found = 1;
          if (m_bk[k]) begin
            eb = 1;
            eo = a[1] ? 32'hBE00_0000 : 32'h0000_BE00;
          end else begin
            er = 1;
            ea = 32'h2000_0000 + {3'b0, m_base, 5'b0} + 32'(4 * k) + {30'b0, a[1:0]};
          end
        end
      end
    end
  endtask

  task automatic check_rsp(input string tag, input logic [31:0] a, input logic f);
    logic [31:0] ea, eo;
    logic er, eb;
    model(a, f, ea, er, eb, eo);
    chk(tag, "valid", {31'b0, rsp_valid}, 32'd1);
    chk(tag, "addr", rsp_addr, ea);
    chk(tag, "remap", {31'b0, rsp_remap}, {31'b0, er});
    chk(tag, "bkpt", {31'b0, rsp_bkpt}, {31'b0, eb});
    chk(tag, "opcode", rsp_opcode, eo);
  endtask

  task automatic req(input logic [31:0] a, input logic f, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_is_fetch = f;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(tag, a, f);
  endtask

  function automatic logic [31:0] caddr(input int k);
    return 32'h0000_1000 + 32'(k * 64);
  endfunction

  task automatic sweep(input string tag_f, input string tag_l);
    for (int k = 0; k < NC; k++)
      for (int off = 0; off < 4; off++) begin
        req(caddr(k) + 32'(off), 1'b1, tag_f);
        req(caddr(k) + 32'(off), 1'b0, tag_l);
      end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4ns);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int k = 0; k < NC; k++) begin m_cen[k] = 0; m_bk[k] = 0; m_word[k] = 0; end
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "rsp_valid", {31'b0, rsp_valid}, 0);
    chk("R10", "rsp_addr", rsp_addr, 0);
    chk("R10", "flags", {30'b0, rsp_remap, rsp_bkpt}, 0);
    chk("R10", "opcode", rsp_opcode, 0);
    rst = 1'b0;
    for (int i = 0; i < NC + 2; i++) rd(i, "R10");

    // R8: configuration and readback, literal mode bit ignored
    wr(1, 32'hEABC_DE1F);
    for (int k = 0; k < NC; k++) wr(k + 2, caddr(k) | 32'hE000_0003);
    for (int i = 0; i < NC + 2; i++) rd(i, "R8");
    for (int k = 0; k < NC; k++) wr(k + 2, caddr(k) | 32'h1);

    // R6: unit disabled, nothing matches
    sweep("R6", "R6");
    wr(0, 32'h1);
    rd(0, "R8");

    // R1 R2 R3: remap for all comparators, both tags
    sweep("R2 R3", "R1 R3");

    // R4: breakpoint mode on two instruction comparators
    wr(3, caddr(1) | 32'h3);
    wr(5, caddr(3) | 32'h3);
    for (int off = 0; off < 4; off++) begin
      req(caddr(1) + 32'(off), 1'b1, "R4");
      req(caddr(3) + 32'(off), 1'b1, "R4");
      req(caddr(3) + 32'(off), 1'b0, "R4");
    end

    // R5: out-of-region aliases never match
    for (int j = 1; j < 8; j++)
      for (int k = 0; k < NC; k++) begin
        req(caddr(k) | (32'(j) << 29), 1'b1, "R5");
        req(caddr(k) | (32'(j) << 29), 1'b0, "R5");
      end

    // R7: overlapping comparators, lowest slot wins
    wr(6, caddr(2) | 32'h1);
    wr(9, caddr(6) | 32'h1);
    req(caddr(2), 1'b1, "R7");
    req(caddr(6) + 2, 1'b0, "R7");
    wr(4, caddr(2));
    req(caddr(2) + 1, 1'b1, "R7");
    wr(8, caddr(6));
    req(caddr(6), 1'b0, "R7");

    // R6: individual enable off
    wr(2, caddr(0));
    req(caddr(0), 1'b1, "R6");

    // R8: write takes effect for the request on the next edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(7); cfg_wdata = 32'h0000_2001;
    m_cen[5] = 1; m_bk[5] = 0; m_word[5] = 32'h0000_2001 >> 2;
    @(negedge clk);
    cfg_we = 1'b0;
    req_valid = 1'b1; req_addr = 32'h0000_2002; req_is_fetch = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp("R8", 32'h0000_2002, 1'b1);

    // R9: idle cycle after a response
    @(negedge clk);
    chk("R9", "idle valid", {31'b0, rsp_valid}, 0);
    chk("R9", "idle flags", {30'b0, rsp_remap, rsp_bkpt}, 0);

    finish_run();
  end
endmodule